// File: doc/BRIEF.md
# Vector Length CSR Unit

This block keeps the length-control state of a vector-capable core: the maximum vector length (MVL), the active vector length (VL), and two element offsets, one for sources and one for destinations. Three CSR access ports reach this state: one for MVL, one for VL, and one for a packed state word that carries all four fields. Each port has a write strobe with a write value and a read strobe. Every access returns one result word, which is meant for the destination register of the instruction.

MVL and VL are written with an offset of one: a written 0 means a length of 1. Every field is clamped against the fields it depends on. The three ports differ in what a write returns. An MVL write returns the old MVL. A VL write returns the new VL. A state write returns the old packed word, in which MVL and VL are stored minus one. If the destination register index is zero, the state still updates but no result is flagged.

Top module: `vlen_csr_unit`

## Requirements
- R1: After reset, MVL is 1, VL is 1, both offsets are 0, and `res_valid` is low with `res_data` zero.
- R2: At all times 1 <= VL <= MVL <= XLEN holds, and both offsets are at most VL-1. An MVL or VL write re-clamps the fields that depend on it in the same cycle.
- R3: An MVL write with value v sets MVL to min(v+1, current MVL), so MVL can only shrink through this port. The write returns the exact MVL from before the write.
- R4: A VL write with value v sets VL to min(v+1, MVL) without wrapping for any v, and returns the new exact VL.
- R5: A read of the MVL port returns exact MVL, and a read of the VL port returns exact VL (not minus one).
- R6: The packed state word holds MVL-1 in bits [5:0], VL-1 in bits [11:6], the source offset in [17:12] and the destination offset in [23:18], with all higher bits zero. A state read returns the current word.
- R7: A state write returns the packed word from before the write. In the same cycle it sets MVL-1 to min(bits[5:0], XLEN-1), then VL-1 to min(bits[11:6], new MVL-1), then each offset to min(its field, new VL-1). Bits above 23 are ignored.
- R8: The result and `res_valid` appear one clock after the strobe. `res_valid` is high for exactly one cycle per access, and `res_data` is zero whenever `res_valid` is low.
- R9: With `dest_reg` equal to 0, `res_valid` stays low and `res_data` stays zero, but a write still updates the state.
- R10: Only one access runs per cycle, chosen by priority: state port first, then VL, then MVL. Within a port, a write takes precedence over a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mvl_we | input | 1 | MVL port write strobe |
| mvl_re | input | 1 | MVL port read strobe |
| mvl_wval | input | XLEN | MVL write value (length minus one) |
| vl_we | input | 1 | VL port write strobe |
| vl_re | input | 1 | VL port read strobe |
| vl_wval | input | XLEN | VL write value (length minus one) |
| st_we | input | 1 | State port write strobe |
| st_re | input | 1 | State port read strobe |
| st_wval | input | XLEN | Packed state write value |
| dest_reg | input | 5 | Destination register index of the access |
| res_data | output | XLEN | Result word for the destination register |
| res_valid | output | 1 | Result present; low for index 0 |

## Verification
The bench targets write values at, above and far above the current limit, including an all-ones VL write. A design that computes v+1 in XLEN bits would wrap that value to a VL of zero. After MVL shrinks, the bench reads VL and the offsets back, which exposes a design that leaves them above the new limit. It also compares the values returned by the three ports, which catches a design that returns old where new is required, or that returns exact values where minus-one values are required. The remaining directed tests check that state bits above 23 are ignored, that a write to index 0 updates the state but returns nothing, and that simultaneous strobes resolve in the stated priority.

// File: rtl/vlen_csr_unit.sv
module vlen_csr_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mvl_we,
  input  logic            mvl_re,
  input  logic [XLEN-1:0] mvl_wval,
  input  logic            vl_we,
  input  logic            vl_re,
  input  logic [XLEN-1:0] vl_wval,
  input  logic            st_we,
  input  logic            st_re,
  input  logic [XLEN-1:0] st_wval,
  input  logic [4:0]      dest_reg,
  output logic [XLEN-1:0] res_data,
  output logic            res_valid
);
  localparam int FW = 6;
  localparam logic [FW-1:0] TOP_M1 = FW'(XLEN - 1);

  logic [FW-1:0] mvl_q, vl_q, src_q, dst_q;
  logic [FW-1:0] mvl_n, vl_n, src_n, dst_n;
  logic [XLEN-1:0] res_n;

  function automatic logic [FW-1:0] clip(input logic [XLEN-1:0] v, input logic [FW-1:0] lim);
    return (v < XLEN'(lim)) ? v[FW-1:0] : lim;
  endfunction

  wire st_sel  = st_we | st_re;
  wire vl_sel  = !st_sel && (vl_we | vl_re);
  wire mvl_sel = !st_sel && !vl_sel && (mvl_we | mvl_re);
  wire any_sel = st_sel | vl_sel | mvl_sel;
  wire [XLEN-1:0] packed_q = XLEN'({dst_q, src_q, vl_q, mvl_q});

  always_comb begin
    mvl_n = mvl_q;
    vl_n  = vl_q;
    src_n = src_q;
    dst_n = dst_q;
    res_n = '0;
    if (st_sel) begin
      res_n = packed_q;
      if (st_we) begin
        mvl_n = clip(XLEN'(st_wval[5:0]), TOP_M1);
        vl_n  = clip(XLEN'(st_wval[11:6]), mvl_n);
        src_n = clip(XLEN'(st_wval[17:12]), vl_n);
        dst_n = clip(XLEN'(st_wval[23:18]), vl_n);
      end
    end else if (vl_sel) begin
      if (vl_we) begin
        vl_n  = clip(vl_wval, mvl_q);
        src_n = clip(XLEN'(src_q), vl_n);
        dst_n = clip(XLEN'(dst_q), vl_n);
      end
      res_n = XLEN'(vl_n) + XLEN'(1);
    end else if (mvl_sel) begin
      res_n = XLEN'(mvl_q) + XLEN'(1);
      if (mvl_we) begin
        mvl_n = clip(mvl_wval, mvl_q);
        vl_n  = clip(XLEN'(vl_q), mvl_n);
        src_n = clip(XLEN'(src_q), vl_n);
        dst_n = clip(XLEN'(dst_q), vl_n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mvl_q     <= '0;
      vl_q      <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      mvl_q     <= mvl_n;
      vl_q      <= vl_n;
      src_q     <= src_n;
      dst_q     <= dst_n;
      res_valid <= any_sel && (dest_reg != 5'd0);
      res_data  <= (any_sel && (dest_reg != 5'd0)) ? res_n : '0;
    end
  end

  assert_len_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_q <= mvl_q) && (mvl_q <= TOP_M1));

  assert_offs_in_vl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q <= vl_q) && (dst_q <= vl_q));

  assert_mvl_no_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mvl_sel && mvl_we) |=> (mvl_q <= $past(mvl_q)));

  assert_vl_returns_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_sel && vl_we && dest_reg != 5'd0) |=> (res_valid && res_data == XLEN'(vl_q) + XLEN'(1)));

  assert_valid_after_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(any_sel));

  assert_x0_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_sel && dest_reg == 5'd0) |=> (!res_valid && res_data == '0));
endmodule

// File: tb/vlen_csr_unit_tb.sv
module vlen_csr_unit_tb;
  localparam int XLEN = 64;

  typedef struct packed {
    logic [1:0]  op;   // 0 MVL port, 1 VL port, 2 state port
    logic        we;
    logic [63:0] wval;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 1'b1, 64'h0000_0000_0030_527F, 64'h0,      4'd7},  // R7 write, old word 0
    '{2'd2, 1'b0, 64'h0,                   64'h24527F, 4'd6},  // R6 dst clamped to 9
    '{2'd0, 1'b0, 64'h0,                   64'd64,     4'd5},  // R5
    '{2'd1, 1'b0, 64'h0,                   64'd10,     4'd5},  // R5
    '{2'd1, 1'b1, 64'd3,                   64'd4,      4'd4},  // R4
    '{2'd2, 1'b0, 64'h0,                   64'hC30FF,  4'd2},  // R2 offsets reclamped
    '{2'd1, 1'b1, 64'd100,                 64'd64,     4'd4},  // R4 limited by MVL
    '{2'd0, 1'b1, 64'd40,                  64'd64,     4'd3},  // R3 returns old
    '{2'd0, 1'b1, 64'd50,                  64'd41,     4'd3},  // R3 no grow
    '{2'd1, 1'b0, 64'h0,                   64'd41,     4'd2},  // R2 VL follows MVL
    '{2'd0, 1'b1, 64'd1,                   64'd41,     4'd3},  // R3
    '{2'd2, 1'b0, 64'h0,                   64'h41041,  4'd2},  // R2
    '{2'd2, 1'b1, 64'hFFFF_FF00_0000_2507, 64'h41041,  4'd7},  // R7 high bits set
    '{2'd2, 1'b0, 64'h0,                   64'h21C7,   4'd7},  // R7 VL clamped to MVL
    '{2'd1, 1'b1, 64'd0,                   64'd1,      4'd4},  // R4
    '{2'd2, 1'b0, 64'h0,                   64'h7,      4'd2},  // R2
    '{2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8,      4'd4}   // R4 no wrap
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mvl_we = 0, mvl_re = 0, vl_we = 0, vl_re = 0, st_we = 0, st_re = 0;
  logic [XLEN-1:0] mvl_wval = '0, vl_wval = '0, st_wval = '0;
  logic [4:0] dest_reg = 5'd1;
  logic [XLEN-1:0] res_data;
  logic res_valid;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  vlen_csr_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .mvl_we(mvl_we), .mvl_re(mvl_re), .mvl_wval(mvl_wval),
    .vl_we(vl_we), .vl_re(vl_re), .vl_wval(vl_wval),
    .st_we(st_we), .st_re(st_re), .st_wval(st_wval),
    .dest_reg(dest_reg), .res_data(res_data), .res_valid(res_valid)
  );

  task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_strobes();
    mvl_we = 0; mvl_re = 0; vl_we = 0; vl_re = 0; st_we = 0; st_re = 0;
  endtask

  task automatic access(input logic [1:0] op, input logic we, input logic [63:0] wval, input logic [4:0] rd);
    @(negedge clk);
    dest_reg = rd;
    case (op)
      2'd0: begin mvl_we = we; mvl_re = !we; mvl_wval = wval; end
      2'd1: begin vl_we = we; vl_re = !we; vl_wval = wval; end
      default: begin st_we = we; st_re = !we; st_wval = wval; end
    endcase
    @(negedge clk);
    clear_strobes();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1, {63'd0, res_valid}, 64'd0, "res_valid in reset");   // R1
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, res_data, 64'd0, "res_data after reset");           // R1
    access(2'd2, 1'b0, 0, 5'd1); chk(1, res_data, 64'h0, "state after reset");
    access(2'd0, 1'b0, 0, 5'd1); chk(1, res_data, 64'd1, "MVL after reset");
    access(2'd1, 1'b0, 0, 5'd1); chk(1, res_data, 64'd1, "VL after reset");

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].op, VECS[i].we, VECS[i].wval, 5'd3);
      chk(int'(VECS[i].req), res_data, VECS[i].exp, $sformatf("vector %0d", i));
      chk(8, {63'd0, res_valid}, 64'd1, $sformatf("valid vector %0d", i));  // R8
    end

    @(negedge clk);
    chk(8, {63'd0, res_valid}, 64'd0, "valid one-cycle pulse");   // R8
    chk(8, res_data, 64'd0, "data zero when idle");

    // R9: write to index 0 updates VL to 3 but returns nothing
    access(2'd1, 1'b1, 64'd2, 5'd0);
    chk(9, {63'd0, res_valid}, 64'd0, "x0 valid");
    chk(9, res_data, 64'd0, "x0 data");
    access(2'd1, 1'b0, 0, 5'd2);
    chk(9, res_data, 64'd3, "VL updated by x0 write");

    // R10: state read beats VL write in the same cycle
    @(negedge clk);
    dest_reg = 5'd4; st_re = 1; vl_we = 1; vl_wval = 64'd0;
    @(negedge clk);
    clear_strobes();
    chk(10, res_data, 64'h87, "state port wins");
    access(2'd1, 1'b0, 0, 5'd4);
    chk(10, res_data, 64'd3, "VL untouched by losing write");

    // R10: write beats read on the MVL port
    @(negedge clk);
    dest_reg = 5'd5; mvl_we = 1; mvl_re = 1; mvl_wval = 64'd0;
    @(negedge clk);
    clear_strobes();
    chk(10, res_data, 64'd8, "MVL write returns old");
    access(2'd0, 1'b0, 0, 5'd5);
    chk(10, res_data, 64'd1, "MVL write took effect");
    access(2'd2, 1'b0, 0, 5'd5);
    chk(2, res_data, 64'h0, "VL and offsets follow MVL of 1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule